// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable ratio N = 64·B + A. It does not use one wide binary counter. A small prescaler divides by either 64 or 65. A swallow counter holds the prescaler at 65 for the first A of its output periods in each output cycle. A main counter ends the cycle after B prescaler periods in total. The result is 65·A + 64·(B − A) = 64·B + A input cycles between output pulses. The prescaler is modelled here as a synthesizable counter on the same clock as the rest of the block.

A new ratio is offered on `cfg_b` and `cfg_a` with a one-cycle strobe on `cfg_load`. The block checks the pair against the allowed ranges. A legal pair is stored and takes effect from the next output-pulse boundary. An illegal pair is dropped and flags `config_error`. All pins are plain control or status pins. There is no streaming data, so there is no valid/ready handshake and no back-pressure. A strobe is always accepted in the cycle it is presented.

Top module: `psd_main_divider`

## Requirements
- R1: While a pair (B, A) is in use, consecutive `div_pulse` assertions are exactly 64·B + A clock cycles apart.
- R2: `div_pulse` is high for exactly one clock cycle per output period.
- R3: Within each output period, the prescaler runs A periods of 65 cycles first and then B − A periods of 64 cycles.
- R4: A pair is legal when 3 ≤ B ≤ 2047, A ≤ 63 and A < B. A `cfg_load` strobe with an illegal pair sets `config_error` high on the next clock cycle.
- R5: An illegal pair leaves the ratio in use unchanged, both for the period in progress and for all later periods.
- R6: A `cfg_load` strobe with a legal pair clears `config_error` on the next clock cycle.
- R7: A legal pair loaded in the middle of a period does not change that period. It applies from the next output-pulse boundary onward.
- R8: After reset the pair in use is B = 3, A = 0, so the period is 192 cycles. `config_error` and `div_pulse` are low while reset is held.
- R9: Changes on `cfg_a` and `cfg_b` while `cfg_load` is low have no effect on the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock at the VCO rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe that offers a new pair |
| cfg_b | input | 11 | Main count B |
| cfg_a | input | 7 | Swallow count A |
| div_pulse | output | 1 | One-cycle pulse at the end of every output period |
| config_error | output | 1 | High after an illegal pair was offered, low after a legal one |

## Verification
`config_error` is registered, so it is sampled on the falling edge one cycle after the strobe. Each period is measured by counting falling edges from one observed `div_pulse` to the next. In every case this count must equal 64·B + A exactly.

A strobe is always given in the cycle right after a pulse. This puts it mid-period, so the first interval measured after it must still show the old ratio and the second interval the new one. The checks compare both intervals against ratios the bench computes from the programmed pair.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned PSD_MOD   = 64;
  localparam int unsigned PSD_B_W   = 11;
  localparam int unsigned PSD_A_W   = 7;
  localparam int unsigned PSD_B_MIN = 3;
  localparam int unsigned PSD_RST_B = 3;
  localparam int unsigned PSD_RST_A = 0;

  // prescaler modulus for the coming prescaler period
  typedef enum logic {
    MODE_BASE = 1'b0,   // divide by MOD
    MODE_SWAL = 1'b1    // divide by MOD + 1
  } psd_mode_e;
endpackage

// File: rtl/psd_cfg_check.sv
module psd_cfg_check #(
  parameter int unsigned A_W   = psd_pkg::PSD_A_W,
  parameter int unsigned B_W   = psd_pkg::PSD_B_W,
  parameter int unsigned MOD   = psd_pkg::PSD_MOD,
  parameter int unsigned B_MIN = psd_pkg::PSD_B_MIN,
  parameter int unsigned RST_A = psd_pkg::PSD_RST_A,
  parameter int unsigned RST_B = psd_pkg::PSD_RST_B
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [A_W-1:0] cfg_a,
  input  logic [B_W-1:0] cfg_b,
  output logic [A_W-1:0] pend_a,
  output logic [B_W-1:0] pend_b,
  output logic           config_error
);
  localparam int unsigned CW = (B_W > A_W) ? B_W : A_W;
  localparam logic [A_W:0]   MOD_X = (A_W+1)'(MOD);
  localparam logic [B_W-1:0] BMIN_X = B_W'(B_MIN);

  logic cfg_ok;
  assign cfg_ok = (cfg_b >= BMIN_X) && ({1'b0, cfg_a} < MOD_X)
                  && (CW'(cfg_a) < CW'(cfg_b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_a       <= A_W'(RST_A);
      pend_b       <= B_W'(RST_B);
      config_error <= 1'b0;
    end else if (cfg_load) begin
      config_error <= !cfg_ok;
      if (cfg_ok) begin
        pend_a <= cfg_a;
        pend_b <= cfg_b;
      end
    end
  end

  a_r4_flag_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && ((cfg_b < BMIN_X) || (CW'(cfg_a) >= CW'(cfg_b))))
      |=> config_error);
  a_r5_bad_keeps_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !cfg_ok) |=> ($stable(pend_a) && $stable(pend_b)));
  a_r9_idle_keeps_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(pend_a) && $stable(pend_b)));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned MOD       = PSD_MOD,
  parameter bit          RST_SWAL  = 1'b0,
  localparam int unsigned CNT_W    = $clog2(MOD + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  psd_mode_e next_mode,
  output logic      pre_tc
);
  localparam logic [CNT_W-1:0] TOP_SWAL = CNT_W'(MOD);
  localparam logic [CNT_W-1:0] TOP_BASE = CNT_W'(MOD - 1);

  logic [CNT_W-1:0] cnt;
  assign pre_tc = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= RST_SWAL ? TOP_SWAL : TOP_BASE;
    else if (pre_tc)
      cnt <= (next_mode == MODE_SWAL) ? TOP_SWAL : TOP_BASE;
    else
      cnt <= cnt - 1'b1;
  end

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP_SWAL);
  a_r3_swal_len: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tc && next_mode == MODE_BASE) |=> (cnt == TOP_BASE));
endmodule

// File: rtl/psd_ab_counter.sv
module psd_ab_counter
  import psd_pkg::*;
#(
  parameter int unsigned A_W   = PSD_A_W,
  parameter int unsigned B_W   = PSD_B_W,
  parameter int unsigned RST_A = PSD_RST_A,
  parameter int unsigned RST_B = PSD_RST_B
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_tc,
  input  logic [A_W-1:0] pend_a,
  input  logic [B_W-1:0] pend_b,
  output psd_mode_e      next_mode,
  output logic           wrap
);
  localparam int unsigned CW = (B_W > A_W) ? B_W : A_W;

  logic [A_W-1:0] a_cnt, a_nxt;
  logic [B_W-1:0] b_cnt, b_nxt;

  assign wrap = pre_tc && (b_cnt == B_W'(1));

  always_comb begin
    a_nxt = a_cnt;
    b_nxt = b_cnt;
    if (wrap) begin
      a_nxt = pend_a;
      b_nxt = pend_b;
    end else if (pre_tc) begin
      b_nxt = b_cnt - 1'b1;
      if (a_cnt != '0) a_nxt = a_cnt - 1'b1;
    end
  end

  assign next_mode = (a_nxt != '0) ? MODE_SWAL : MODE_BASE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_cnt <= A_W'(RST_A);
      b_cnt <= B_W'(RST_B);
    end else begin
      a_cnt <= a_nxt;
      b_cnt <= b_nxt;
    end
  end

  a_r1_b_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    b_cnt != '0);
  a_r3_a_below_b: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(a_cnt) < CW'(b_cnt));
  a_r7_hold_midway: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_tc |=> ($stable(a_cnt) && $stable(b_cnt)));
endmodule

// File: rtl/psd_main_divider.sv
module psd_main_divider
  import psd_pkg::*;
#(
  parameter int unsigned MOD   = PSD_MOD,
  parameter int unsigned A_W   = PSD_A_W,
  parameter int unsigned B_W   = PSD_B_W,
  parameter int unsigned B_MIN = PSD_B_MIN,
  parameter int unsigned RST_A = PSD_RST_A,
  parameter int unsigned RST_B = PSD_RST_B
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_load,
  input  logic [B_W-1:0] cfg_b,
  input  logic [A_W-1:0] cfg_a,
  output logic           div_pulse,
  output logic           config_error
);
  logic [A_W-1:0] pend_a;
  logic [B_W-1:0] pend_b;
  logic           pre_tc;
  logic           wrap;
  psd_mode_e      next_mode;

  psd_cfg_check #(
    .A_W(A_W), .B_W(B_W), .MOD(MOD), .B_MIN(B_MIN),
    .RST_A(RST_A), .RST_B(RST_B)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_a(cfg_a), .cfg_b(cfg_b),
    .pend_a(pend_a), .pend_b(pend_b), .config_error(config_error)
  );

  psd_prescaler #(
    .MOD(MOD), .RST_SWAL(RST_A != 0)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .next_mode(next_mode), .pre_tc(pre_tc)
  );

  psd_ab_counter #(
    .A_W(A_W), .B_W(B_W), .RST_A(RST_A), .RST_B(RST_B)
  ) u_ab (
    .clk(clk), .rst_n(rst_n), .pre_tc(pre_tc),
    .pend_a(pend_a), .pend_b(pend_b),
    .next_mode(next_mode), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) div_pulse <= 1'b0;
    else        div_pulse <= wrap;
  end

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);
  a_r2_follows_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> div_pulse);
endmodule

// File: tb/tb_psd_main_divider.sv
module tb_psd_main_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [10:0] cfg_b = '0;
  logic [6:0]  cfg_a = '0;
  logic        div_pulse;
  logic        config_error;

  int n_checks = 0;
  int n_err    = 0;
  int cur_n    = 192;

  always #4ns clk = ~clk;

  psd_main_divider dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_b(cfg_b), .cfg_a(cfg_a),
    .div_pulse(div_pulse), .config_error(config_error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_interval(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!div_pulse && cyc < 140000);
  endtask

  // called right after a pulse was seen at a falling edge
  task automatic offer(input int a, input int b, input bit legal);
    int c1, c2, nn;
    cfg_a    = 7'(a);
    cfg_b    = 11'(b);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    if (legal) check(config_error == 1'b0, "R6", config_error, 0);
    else       check(config_error == 1'b1, "R4", config_error, 1);
    run_interval(c1);
    c1++;
    if (legal) check(c1 == cur_n, "R7", c1, cur_n);
    else       check(c1 == cur_n, "R5", c1, cur_n);
    nn = legal ? 64 * b + a : cur_n;
    run_interval(c2);
    if (legal) check(c2 == nn, "R1", c2, nn);
    else       check(c2 == nn, "R5", c2, nn);
    cur_n = nn;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    check(div_pulse == 1'b0, "R8", div_pulse, 0);
    check(config_error == 1'b0, "R8", config_error, 0);
    rst_n = 1'b1;
    run_interval(c);
    run_interval(c);
    check(c == 192, "R8", c, 192);
    // R2: pulse drops on the next cycle
    @(negedge clk);
    check(div_pulse == 1'b0, "R2", div_pulse, 0);
    run_interval(c);
    c++;
    check(c == 192, "R1", c, 192);
    // R9: inputs move without a strobe
    cfg_a = 7'd5;
    cfg_b = 11'd9;
    run_interval(c);
    check(c == 192, "R9", c, 192);
    run_interval(c);
    check(c == 192, "R9", c, 192);
    // near-exhaustive sweep of small pairs
    for (int b = 3; b <= 5; b++)
      for (int a = 0; a < b; a++)
        offer(a, b, 1'b1);
    // illegal pairs
    offer(3, 3, 1'b0);
    offer(100, 64, 1'b0);
    offer(0, 2, 1'b0);
    offer(0, 0, 1'b0);
    offer(63, 63, 1'b0);
    // upper ends of the range
    offer(63, 64, 1'b1);
    offer(0, 65, 1'b1);
    offer(17, 80, 1'b1);
    offer(2, 3, 1'b1);
    offer(63, 2047, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule